// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory with 2048 one-byte locations. It oversamples the clock and data lines with the system clock and recognises START and STOP. It then walks through a fixed byte sequence: a command byte, an optional low-address byte, and then either write data or read data. The storage is a synthesizable array of registers.

The command byte holds a fixed leading one, a three-bit device select, the three upper address bits and a direction bit. The device select is compared with three strap pins, and its middle bit is compared inverted, so eight of these slaves can share one bus. An 11-bit location counter steps after every written byte and after every byte sent. Sequential reads and writes therefore run through the array, and a later read with no address phase resumes where the last transfer stopped.

The block never drives the data line high. It only asserts a pull-down enable, which an open-drain pad outside the block turns into a low level.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the pull-down enable `sda_pull_o` is low and the slave waits for a START.
- R2: After a START, the first byte is a command byte, laid out MSB first as {1, s2, s1, s0, a10, a9, a8, dir}. It is acknowledged only when bit 7 is 1 and {s2, s1, s0} equals {cs_pins[2], ~cs_pins[1], cs_pins[0]}. The acknowledge holds the line low for the whole ninth clock.
- R3: A command byte that does not match gets no acknowledge. Every later byte is then ignored, gets no acknowledge and writes nothing, until the next START or STOP.
- R4: A matched command with dir=0 loads address bits 10..8 from command bits 3..1. The next byte is acknowledged and loads address bits 7..0.
- R5: Each data byte after the address byte is acknowledged and stored at the counter. The counter then increments.
- R6: A matched command with dir=1 makes the slave send the byte at the counter, MSB first, with each bit driven while SCL is low. The counter increments after each byte sent.
- R7: The slave sends the next byte while the master acknowledges. After a byte that gets no acknowledge, the slave releases the line and stays silent until START or STOP, so further clocks read all ones.
- R8: In a read command, bits 3..1 are ignored and the counter is left unchanged, so a read with no address phase continues at the location after the last one accessed.
- R9: The counter wraps from 2047 to 0 in both writes and reads.
- R10: The pull-down enable only rises while the synchronized SCL is low.
- R11: A repeated START restarts command-byte reception from any state. A STOP returns the slave to idle, where bytes clocked without a START get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| cs_pins | input | 3 | Strap pins for device selection |
| sda_pull_o | output | 1 | Data line pull-down enable (1 = drive low) |

## Verification
The bench builds the block with its default values: an 11-bit address (2048 locations) and two synchronizer stages. The full address width makes location 2047 reachable through the command and address bytes, so the wrap to 0 is tested on the real array and not on a shrunk copy. The two-stage synchronizer plus the edge register adds about three cycles of latency. This is well inside the bench's eight-cycle quarter bit, so the ninth-clock acknowledge and each driven read bit settle before the master samples them.

// File: rtl/eei_pkg.sv
package eei_pkg;
    localparam int BYTE_W = 8;
    localparam int CS_W   = 3;
    localparam int HI_W   = 3;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_ACK,
        LS_TX,
        LS_MACK,
        LS_IGN
    } link_st_e;

    typedef enum logic [1:0] {
        RK_CMD,
        RK_ADDR,
        RK_DATA
    } rx_kind_e;

    typedef struct packed {
        logic            lead;
        logic [CS_W-1:0] sel;
        logic [HI_W-1:0] hi;
        logic            rd;
    } cmd_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } line_ev_t;

    function automatic logic cmd_hits(cmd_t c, logic [CS_W-1:0] pins);
        return c.lead && (c.sel == {pins[2], ~pins[1], pins[0]});
    endfunction
endpackage

// File: rtl/eei_line_sync.sv
module eei_line_sync
    import eei_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end
        assign cur[g] = chain[STAGES-1];
        assign prv[g] = last;
    end

    always_comb begin
        ev.scl   = cur[1];
        ev.sda   = cur[0];
        ev.rise  = cur[1] & ~prv[1];
        ev.fall  = ~cur[1] & prv[1];
        ev.start = cur[1] & prv[1] & prv[0] & ~cur[0];
        ev.stop  = cur[1] & prv[1] & ~prv[0] & cur[0];
    end
endmodule

// File: rtl/eei_store.sv
module eei_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[waddr] <= wdata;
    end

    assign rdata = arr[raddr];
endmodule

// File: rtl/eei_link.sv
module eei_link
    import eei_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [CS_W-1:0]   cs_pins,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sda_pull
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    link_st_e          st;
    rx_kind_e          kind;
    logic [BIT_W-1:0]  bitcnt;
    logic              got_byte;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic              rd_mode;
    logic              m_acked;
    logic [ADDR_W-1:0] cnt;
    cmd_t              cmd;

    assign cmd       = cmd_t'(shreg);
    assign mem_raddr = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LS_IDLE;
            kind      <= RK_CMD;
            bitcnt    <= '0;
            got_byte  <= 1'b0;
            shreg     <= '0;
            txsh      <= '0;
            rd_mode   <= 1'b0;
            m_acked   <= 1'b0;
            cnt       <= '0;
            sda_pull  <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (ev.stop) begin
                st       <= LS_IDLE;
                sda_pull <= 1'b0;
            end else if (ev.start) begin
                st       <= LS_RX;
                kind     <= RK_CMD;
                bitcnt   <= '0;
                got_byte <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                case (st)
                    LS_RX: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) got_byte <= 1'b1;
                        end else if (ev.fall && got_byte) begin
                            got_byte <= 1'b0;
                            bitcnt   <= '0;
                            case (kind)
                                RK_CMD: begin
                                    if (cmd_hits(cmd, cs_pins)) begin
                                        sda_pull <= 1'b1;
                                        st       <= LS_ACK;
                                        rd_mode  <= cmd.rd;
                                        if (!cmd.rd) cnt[ADDR_W-1 -: HI_W] <= cmd.hi;
                                    end else begin
                                        st <= LS_IGN;
                                    end
                                end
                                RK_ADDR: begin
                                    cnt[BYTE_W-1:0] <= shreg;
                                    sda_pull        <= 1'b1;
                                    st              <= LS_ACK;
                                end
                                default: begin
                                    mem_we    <= 1'b1;
                                    mem_waddr <= cnt;
                                    mem_wdata <= shreg;
                                    cnt       <= cnt + 1'b1;
                                    sda_pull  <= 1'b1;
                                    st        <= LS_ACK;
                                end
                            endcase
                        end
                    end
                    LS_ACK: begin
                        if (ev.fall) begin
                            if (rd_mode) begin
                                txsh     <= mem_rdata;
                                sda_pull <= ~mem_rdata[BYTE_W-1];
                                cnt      <= cnt + 1'b1;
                                bitcnt   <= '0;
                                st       <= LS_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= LS_RX;
                                kind     <= (kind == RK_CMD) ? RK_ADDR : RK_DATA;
                            end
                        end
                    end
                    LS_TX: begin
                        if (ev.fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_pull <= 1'b0;
                                st       <= LS_MACK;
                            end else begin
                                bitcnt   <= bitcnt + 1'b1;
                                txsh     <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~txsh[BYTE_W-2];
                            end
                        end
                    end
                    LS_MACK: begin
                        if (ev.rise) begin
                            m_acked <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (m_acked) begin
                                txsh     <= mem_rdata;
                                sda_pull <= ~mem_rdata[BYTE_W-1];
                                cnt      <= cnt + 1'b1;
                                bitcnt   <= '0;
                                st       <= LS_TX;
                            end else begin
                                st <= LS_IGN;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: the pull-down only engages after SCL was seen low
    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !$past(ev.scl));

    // R2: the acknowledge window holds the line low
    assert_ack_drive_R2: assert property (@(posedge clk) disable iff (rst)
        (st == LS_ACK) |-> sda_pull);

    // R3: a deselected slave stays off the line
    assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (st == LS_IGN && $past(st) == LS_IGN) |-> !sda_pull);

    // R5: every stored byte is acknowledged
    assert_write_acked_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> sda_pull);

    // R9: the counter wraps after the top location
    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_waddr == TOP_ADDR) |-> (cnt == '0));
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eei_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] cs_pins,
    output logic       sda_pull_o
);
    line_ev_t          ev;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [BYTE_W-1:0] wdata;
    logic [BYTE_W-1:0] rdata;

    eei_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eei_link #(.ADDR_W(ADDR_W)) u_link (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .cs_pins   (cs_pins),
        .mem_rdata (rdata),
        .mem_raddr (raddr),
        .mem_we    (we),
        .mem_waddr (waddr),
        .mem_wdata (wdata),
        .sda_pull  (sda_pull_o)
    );

    eei_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );
endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] cs_pins = 3'b011;
    logic       sda_pull;
    logic       sda_line;
    int         checks = 0;
    int         fails = 0;
    int         r10_viol = 0;
    logic       prev_pull = 1'b0;

    assign sda_line = ~(m_low | sda_pull);

    always #2 clk = ~clk;

    serial_eeprom_slave u_serial_eeprom_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .cs_pins    (cs_pins),
        .sda_pull_o (sda_pull)
    );

    always @(negedge clk) begin
        if (sda_pull && !prev_pull && scl) r10_viol++;
        prev_pull <= sda_pull;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; half(); scl = 1'b1; half();
        m_low = 1'b1; half(); scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; half(); scl = 1'b1; half();
        m_low = 1'b0; half();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; half();
            scl = 1'b1; half();
            scl = 1'b0; half();
        end
        m_low = 1'b0; half();
        scl = 1'b1; half();
        ack = ~sda_line;
        scl = 1'b0; half();
    endtask

    task automatic get_byte(output logic [7:0] b, input logic ack_it);
        for (int i = 7; i >= 0; i--) begin
            m_low = 1'b0; half();
            scl = 1'b1; half();
            b[i] = sda_line;
            scl = 1'b0; half();
        end
        m_low = ack_it; half();
        scl = 1'b1; half();
        scl = 1'b0; half();
        m_low = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 idle pull-down after reset", {7'd0, sda_pull}, 8'h00);
    endtask

    task automatic t_write_seq();
        logic a;
        bus_start();
        put_byte(8'h9A, a); check("R2 matched write command ack", {7'd0, a}, 8'h01);
        put_byte(8'h3C, a); check("R4 address byte ack", {7'd0, a}, 8'h01);
        put_byte(8'h11, a); check("R5 data byte 0 ack", {7'd0, a}, 8'h01);
        put_byte(8'h22, a); check("R5 data byte 1 ack", {7'd0, a}, 8'h01);
        put_byte(8'h33, a); check("R5 data byte 2 ack", {7'd0, a}, 8'h01);
        put_byte(8'h44, a); check("R5 data byte 3 ack", {7'd0, a}, 8'h01);
        bus_stop();
    endtask

    task automatic t_read_seq();
        logic a;
        logic [7:0] d;
        bus_start();
        put_byte(8'h9A, a);
        put_byte(8'h3C, a);
        bus_start();
        put_byte(8'h9F, a); check("R11 R8 read command after repeated start", {7'd0, a}, 8'h01);
        get_byte(d, 1'b1); check("R6 R4 read byte at 0x53C", d, 8'h11);
        get_byte(d, 1'b1); check("R6 read byte at 0x53D", d, 8'h22);
        get_byte(d, 1'b0); check("R7 read byte at 0x53E then nack", d, 8'h33);
        get_byte(d, 1'b0); check("R7 line released after nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_current_read();
        logic a;
        logic [7:0] d;
        bus_start();
        put_byte(8'h91, a); check("R8 current-address read ack", {7'd0, a}, 8'h01);
        get_byte(d, 1'b0); check("R8 continues at 0x53F", d, 8'h44);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        logic [7:0] d;
        bus_start();
        put_byte(8'hBA, a); check("R3 select without inversion nack", {7'd0, a}, 8'h00);
        put_byte(8'h3C, a); check("R3 later byte ignored", {7'd0, a}, 8'h00);
        put_byte(8'hEE, a); check("R3 later data ignored", {7'd0, a}, 8'h00);
        bus_stop();
        bus_start();
        put_byte(8'h1A, a); check("R2 bit7 clear nack", {7'd0, a}, 8'h00);
        bus_stop();
        bus_start();
        put_byte(8'h9A, a);
        put_byte(8'h3C, a);
        bus_start();
        put_byte(8'h91, a);
        get_byte(d, 1'b0); check("R3 memory untouched by ignored write", d, 8'h11);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic a;
        logic [7:0] d;
        bus_start();
        put_byte(8'h9E, a);
        put_byte(8'hFF, a);
        put_byte(8'hA5, a); check("R9 write at 0x7FF ack", {7'd0, a}, 8'h01);
        put_byte(8'h5A, a); check("R9 write after wrap ack", {7'd0, a}, 8'h01);
        bus_stop();
        bus_start();
        put_byte(8'h9E, a);
        put_byte(8'hFF, a);
        bus_start();
        put_byte(8'h91, a);
        get_byte(d, 1'b1); check("R9 read 0x7FF", d, 8'hA5);
        get_byte(d, 1'b0); check("R9 read wraps to 0x000", d, 8'h5A);
        bus_stop();
    endtask

    task automatic t_cs_change();
        logic a;
        cs_pins = 3'b100;
        half();
        bus_start();
        put_byte(8'hE0, a); check("R2 new strap select 110 ack", {7'd0, a}, 8'h01);
        bus_stop();
        bus_start();
        put_byte(8'h90, a); check("R2 old select now nack", {7'd0, a}, 8'h00);
        bus_stop();
        cs_pins = 3'b011;
        half();
    endtask

    task automatic t_no_start();
        logic a;
        put_byte(8'h9A, a); check("R11 byte without start ignored", {7'd0, a}, 8'h00);
        bus_stop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_seq();
        t_read_seq();
        t_current_read();
        t_mismatch();
        t_wrap();
        t_cs_change();
        t_no_start();
        check("R10 pull-down rises only with SCL low", r10_viol[7:0], 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule